// File: doc/BRIEF.md
# Monochrome Framebuffer Scanout Engine

This block turns a packed one-bit-per-pixel image held in memory into a raster pixel stream. Free-running horizontal and vertical counters define the active window and the blanking intervals. During the active window the engine reads one byte of video memory for every eight pixels, loads it into a shift register and shifts the pixels out, leftmost first. It also produces a data-enable and two active-low sync pulses. The memory is word-organised, and inside every 16-bit word the byte at the odd address is shown first. To do this, the byte index within a line is XORed with one before it is put on the read port.

A single 16-bit control register with per-byte write enables sits next to the scanout path. Its top bit gates the picture. When that bit is clear, the pixel output stays black, but timing, sync and fetches keep running. The default geometry is 1152 x 900 visible pixels. With the default blanking parameters, a pixel clock of about 104 MHz gives a 72 Hz refresh.

Top module: `mono_scanout`

## Requirements
- R1: A line lasts H_ACTIVE+H_FP+H_SYNC+H_BP clocks and a frame lasts V_ACTIVE+V_FP+V_SYNC+V_BP lines. `hsync_n` is low for H_SYNC pixel slots, starting H_FP slots after the last active pixel of each line. `vsync_n` is low for all V_SYNC lines, starting V_FP lines after the last active line. Both are aligned with `de_out`.
- R2: `de_out` is high for exactly the H_ACTIVE x V_ACTIVE pixel slots of the visible window. Pixel (x,y) appears two clocks after the counters reach (x,y).
- R3: `rd_en` pulses for one clock at the first pixel slot of each byte inside the visible window, which is every 8th clock of an active line. It is never high during horizontal or vertical blanking.
- R4: The read address for byte k of line y is y*(H_ACTIVE/8) + (k XOR 1), so the two bytes of each 16-bit word are fetched in swapped order.
- R5: Read data must arrive one clock after `rd_en`. Bit 7 of a fetched byte is the leftmost of its eight pixels and bit 0 is the rightmost. Consecutive bytes follow one another with no gap pixel.
- R6: `pix_out` = 1 means white and 0 means black. While bit 15 of the control register is 0, `pix_out` is 0. Setting the bit takes effect on the pixel shown in the clock after the write edge.
- R7: The control register is 16 bits, read back on `reg_rdata`. A write with `reg_wr` high updates bits 7:0 only when `reg_be[0]` is set and bits 15:8 only when `reg_be[1]` is set. A write with no lane enabled changes nothing.
- R8: After a synchronous reset, the control register is 0, the counters start at pixel (0,0) of the frame, `de_out` and `pix_out` are 0, and both syncs are high.
- R9: `pix_out` is 0 whenever `de_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_be | input | 2 | Byte-lane enables for the write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Current control register value |
| rd_en | output | 1 | Video memory byte read strobe |
| rd_addr | output | ADDR_W | Byte address of the read |
| rd_data | input | 8 | Read data, valid one clock after `rd_en` |
| pix_out | output | 1 | Pixel value, 1 = white |
| de_out | output | 1 | High inside the visible window |
| hsync_n | output | 1 | Active-low horizontal sync |
| vsync_n | output | 1 | Active-low vertical sync |

## Verification
The assertions assume that `rd_data` is valid exactly one clock after each `rd_en`. They also assume H_ACTIVE is a multiple of 16, so the swapped byte index stays inside its own line, and that each horizontal blanking part is at least one clock long. The bench memory model answers every read with a fixed one-cycle latency. It uses a small legal geometry of 64 x 6 pixels and rewrites the image only while the counters are in vertical blanking. Control writes are single-cycle pulses placed anywhere in the frame, including in the middle of active lines.

// File: rtl/mono_scan_pkg.sv
// Shared definitions for the monochrome scanout engine.
// Assumes: one pixel per clock, eight pixels packed per byte.
package mono_scan_pkg;
    // Timing flags that travel through the pixel pipeline together.
    typedef struct packed {
        logic de;
        logic hs_n;
        logic vs_n;
    } raster_t;

    localparam raster_t RASTER_IDLE = '{de: 1'b0, hs_n: 1'b1, vs_n: 1'b1};
    localparam int unsigned PIX_PER_BYTE = 8;
    localparam int unsigned CTRL_W       = 16;
    localparam int unsigned CTRL_EN_BIT  = 15;
    localparam int unsigned PIPE_DEPTH   = 2;   // fetch + shifter load
endpackage

// File: rtl/mscan_timing.sv
// Raster timing generator: horizontal and vertical counters plus the
// visible-window and sync flags derived from them.
// Assumes every blanking part is at least one clock/line long.
module mscan_timing
    import mono_scan_pkg::*;
#(
    parameter int H_ACTIVE = 1152,
    parameter int H_FP     = 64,
    parameter int H_SYNC   = 112,
    parameter int H_BP     = 216,
    parameter int V_ACTIVE = 900,
    parameter int V_FP     = 3,
    parameter int V_SYNC   = 4,
    parameter int V_BP     = 30,
    parameter int HW       = 11,
    parameter int VW       = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] hcnt,
    output logic          line_end,
    output logic          frame_end,
    output logic          vis_line,
    output raster_t       ras
);
    localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
    localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
    localparam int HS_BEG  = H_ACTIVE + H_FP;
    localparam int HS_END  = HS_BEG + H_SYNC;
    localparam int VS_BEG  = V_ACTIVE + V_FP;
    localparam int VS_END  = VS_BEG + V_SYNC;

    logic [VW-1:0] vcnt;

    assign line_end  = (hcnt == HW'(H_TOTAL - 1));
    assign frame_end = line_end && (vcnt == VW'(V_TOTAL - 1));
    assign vis_line  = (vcnt < VW'(V_ACTIVE));

    // Purpose: advance the pixel/line position, wrapping at line and frame ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (line_end) begin
            hcnt <= '0;
            vcnt <= frame_end ? '0 : vcnt + 1'b1;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    // Purpose: decode the window and sync intervals from the counters.
    always_comb begin
        ras.de   = (hcnt < HW'(H_ACTIVE)) && vis_line;
        ras.hs_n = !((hcnt >= HW'(HS_BEG)) && (hcnt < HW'(HS_END)));
        ras.vs_n = !((vcnt >= VW'(VS_BEG)) && (vcnt < VW'(VS_END)));
    end
endmodule

// File: rtl/mscan_fetch.sv
// Byte fetch address generator. Issues one read per eight visible pixels
// and swaps the bytes inside each 16-bit word.
// Assumes H_ACTIVE is a multiple of 16 and HW >= 4.
module mscan_fetch
    import mono_scan_pkg::*;
#(
    parameter int H_ACTIVE = 1152,
    parameter int HW       = 11,
    parameter int ADDR_W   = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HW-1:0]     hcnt,
    input  logic              pix_vis,
    input  logic              line_end,
    input  logic              frame_end,
    input  logic              vis_line,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr
);
    localparam int BYTES_PER_LINE = H_ACTIVE / PIX_PER_BYTE;
    localparam int SUB_W          = $clog2(PIX_PER_BYTE);
    localparam int BIDX_W         = HW - SUB_W;

    logic [ADDR_W-1:0] line_base;
    logic [BIDX_W-1:0] byte_idx;

    // Purpose: keep the start address of the current line without a multiplier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_base <= '0;
        end else if (frame_end) begin
            line_base <= '0;
        end else if (line_end && vis_line) begin
            line_base <= line_base + ADDR_W'(BYTES_PER_LINE);
        end
    end

    // Purpose: strobe a read at each byte boundary of the window, word-swapped.
    always_comb begin
        byte_idx = hcnt[HW-1:SUB_W];
        rd_en    = pix_vis && (hcnt[SUB_W-1:0] == '0);
        rd_addr  = line_base + ADDR_W'(byte_idx ^ BIDX_W'(1));
    end
endmodule

// File: rtl/mscan_ctrl.sv
// Control register with one write enable per byte lane.
// Assumes REG_W is a multiple of 8.
module mscan_ctrl #(
    parameter int REG_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [REG_W/8-1:0] be,
    input  logic [REG_W-1:0]   wdata,
    output logic [REG_W-1:0]   q
);
    localparam int LANES = REG_W / 8;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Purpose: update this byte lane only when its enable is set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[g*8 +: 8] <= '0;
            end else if (wr && be[g]) begin
                q[g*8 +: 8] <= wdata[g*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/mscan_pixel.sv
// Pixel shifter and timing delay line. Loads each fetched byte the clock
// its data returns and shifts MSB first. Delays the timing flags by the
// same PIPE_DEPTH clocks so that they line up with the pixels.
// Assumes read data is valid exactly one clock after the read strobe.
module mscan_pixel
    import mono_scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fetch,
    input  logic [7:0] rd_data,
    input  raster_t    ras_in,
    input  logic       enable,
    output logic       pix,
    output raster_t    ras_out
);
    logic       load;
    logic [7:0] shreg;
    raster_t    stage [PIPE_DEPTH];

    // Purpose: remember which clock carries returning read data.
    always_ff @(posedge clk) begin
        if (!rst_n) load <= 1'b0;
        else        load <= fetch;
    end

    // Purpose: reload on returning data, otherwise shift toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)    shreg <= '0;
        else if (load) shreg <= rd_data;
        else           shreg <= {shreg[6:0], 1'b0};
    end

    for (genvar s = 0; s < PIPE_DEPTH; s++) begin : g_stage
        // Purpose: one delay stage of the timing flags.
        always_ff @(posedge clk) begin
            if (!rst_n)      stage[s] <= RASTER_IDLE;
            else if (s == 0) stage[s] <= ras_in;
            else             stage[s] <= stage[(s == 0) ? 0 : s-1];
        end
    end

    assign ras_out = stage[PIPE_DEPTH-1];
    assign pix     = ras_out.de && enable && shreg[7];
endmodule

// File: rtl/mono_scanout.sv
// Top of the monochrome scanout engine: timing, fetch, pixel shifter and
// control register. Assumes read data returns one clock after rd_en.
module mono_scanout
    import mono_scan_pkg::*;
#(
    parameter int H_ACTIVE = 1152,
    parameter int H_FP     = 64,
    parameter int H_SYNC   = 112,
    parameter int H_BP     = 216,
    parameter int V_ACTIVE = 900,
    parameter int V_FP     = 3,
    parameter int V_SYNC   = 4,
    parameter int V_BP     = 30,
    parameter int ADDR_W   = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_be,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              pix_out,
    output logic              de_out,
    output logic              hsync_n,
    output logic              vsync_n
);
    localparam int HW = $clog2(H_ACTIVE + H_FP + H_SYNC + H_BP);
    localparam int VW = $clog2(V_ACTIVE + V_FP + V_SYNC + V_BP);

    logic [HW-1:0] hcnt;
    logic          line_end, frame_end, vis_line;
    raster_t       ras_now, ras_dly;

    mscan_timing #(
        .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
        .HW(HW), .VW(VW)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .line_end(line_end),
        .frame_end(frame_end), .vis_line(vis_line), .ras(ras_now)
    );

    mscan_fetch #(.H_ACTIVE(H_ACTIVE), .HW(HW), .ADDR_W(ADDR_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .pix_vis(ras_now.de),
        .line_end(line_end), .frame_end(frame_end), .vis_line(vis_line),
        .rd_en(rd_en), .rd_addr(rd_addr)
    );

    mscan_ctrl #(.REG_W(CTRL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .be(reg_be),
        .wdata(reg_wdata), .q(reg_rdata)
    );

    mscan_pixel u_pixel (
        .clk(clk), .rst_n(rst_n), .fetch(rd_en), .rd_data(rd_data),
        .ras_in(ras_now), .enable(reg_rdata[CTRL_EN_BIT]),
        .pix(pix_out), .ras_out(ras_dly)
    );

    assign de_out  = ras_dly.de;
    assign hsync_n = ras_dly.hs_n;
    assign vsync_n = ras_dly.vs_n;
endmodule

// File: rtl/mono_scanout_chk.sv
// Property checker for mono_scanout, attached with bind below.
module mono_scanout_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [1:0]  reg_be,
    input logic [15:0] reg_rdata,
    input logic        rd_en,
    input logic        pix_out,
    input logic        de_out,
    input logic        hsync_n
);
    // R3: reads are at least eight clocks apart, so never back to back
    p_fetch_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);

    // R2: a fetched byte is shown two clocks later inside the window
    p_fetch_to_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> ##1 de_out);

    // R9: no white pixel outside the window
    p_dark_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pix_out |-> de_out);

    // R6: a cleared enable bit keeps the output black
    p_gate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[15] |-> !pix_out);

    // R1: the horizontal sync pulse lies in blanking
    p_sync_blank_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n |-> !de_out);

    // R7: upper lane holds when only the lower lane is written
    p_lane_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_be[1]) |=> $stable(reg_rdata[15:8]));

    // R7: lower lane holds when only the upper lane is written
    p_lane_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_be[0]) |=> $stable(reg_rdata[7:0]));
endmodule

bind mono_scanout mono_scanout_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_be(reg_be),
    .reg_rdata(reg_rdata), .rd_en(rd_en), .pix_out(pix_out),
    .de_out(de_out), .hsync_n(hsync_n)
);

// File: tb/sim_mono_scanout.sv
`timescale 1ns/1ps
module sim_mono_scanout;
    localparam int HA = 64, HF = 4, HS = 6, HB = 6;
    localparam int VA = 6,  VF = 1, VS = 2, VB = 1;
    localparam int HT = HA + HF + HS + HB;
    localparam int VT = VA + VF + VS + VB;
    localparam int BPL = HA / 8;
    localparam int MEM_N = BPL * VA;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_be = '0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data = '0;
    logic          pix_out, de_out, hsync_n, vsync_n;

    int n_checks = 0;
    int n_fail   = 0;

    mono_scanout #(
        .H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
        .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB), .ADDR_W(AW)
    ) u0 (.*);

    always #2 clk = ~clk;   // 250 MHz

    // ---------------- reference model ----------------
    typedef struct { bit de; bit hs; bit vs; bit px; } ent_t;
    ent_t   q[$];
    logic [7:0] mem [MEM_N];
    logic [15:0] m_ctrl = '0;
    bit     rst_q = 1'b0;
    bit     edge_seen = 1'b0;
    int     h = 0, v = 0, frame_no = 0;

    function automatic logic [7:0] pat(int i, int f);
        logic [7:0] fix [4] = '{8'h80, 8'h01, 8'hFF, 8'h00};
        if (f == 0) return fix[i % 4];
        return 8'((i * 29 + f * 71 + 3) & 255);
    endfunction

    task automatic fill(int f);
        for (int i = 0; i < MEM_N; i++) mem[i] = pat(i, f);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (h=%0d v=%0d)", req, act, exp, h, v);
        end
    endtask

    initial fill(0);

    // memory with one-clock latency, register-model and reset tracking
    always @(posedge clk) begin
        edge_seen <= 1'b1;
        rst_q     <= rst_n;
        if (rd_en && int'(rd_addr) < MEM_N) rd_data <= mem[int'(rd_addr)];
        if (!rst_n) m_ctrl <= '0;
        else if (reg_wr) begin
            if (reg_be[0]) m_ctrl[7:0]  <= reg_wdata[7:0];
            if (reg_be[1]) m_ctrl[15:8] <= reg_wdata[15:8];
        end
    end

    // per-clock comparison at the falling edge
    always @(negedge clk) begin
        ent_t e, x;
        bit act;
        if (edge_seen) begin
            if (!rst_q) begin
                h = 0; v = 0;
                q.delete();
                x = '{de: 1'b0, hs: 1'b1, vs: 1'b1, px: 1'b0};
                q.push_back(x);
                q.push_back(x);
            end
            act = (h < HA) && (v < VA);
            // R3: read strobe only at byte starts of the window
            check("R3 rd_en", int'(rd_en), int'(act && (h % 8 == 0)));
            // R4: swapped byte address
            if (act && (h % 8 == 0))
                check("R4 rd_addr", int'(rd_addr), v * BPL + ((h / 8) ^ 1));
            e.de = act;
            e.hs = !(h >= HA + HF && h < HA + HF + HS);
            e.vs = !(v >= VA + VF && v < VA + VF + VS);
            e.px = act ? mem[v * BPL + ((h / 8) ^ 1)][7 - (h % 8)] : 1'b0;
            q.push_back(e);
            x = q.pop_front();
            check("R2 de_out", int'(de_out), int'(x.de));
            check("R1 hsync_n", int'(hsync_n), int'(x.hs));
            check("R1 vsync_n", int'(vsync_n), int'(x.vs));
            // R5/R6/R9: pixel value, bit order, gating, dark blanking
            check("R5 R6 R9 pix_out", int'(pix_out), int'(x.de && m_ctrl[15] && x.px));
            h++;
            if (h == HT) begin
                h = 0;
                v++;
                if (v == VT) v = 0;
            end
            if (h == 0 && v == VA) begin
                frame_no++;
                fill(frame_no);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [1:0] be, input logic [15:0] d, input logic [15:0] exp);
        @(negedge clk);
        reg_wr = 1'b1; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = '0; reg_wdata = '0;
        check("R7 reg_rdata", int'(reg_rdata), int'(exp));
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R8: reset state
        check("R8 reg_rdata", int'(reg_rdata), 0);
        check("R8 de_out", int'(de_out), 0);
        check("R8 pix_out", int'(pix_out), 0);
        check("R8 hsync_n", int'(hsync_n), 1);
        check("R8 vsync_n", int'(vsync_n), 1);
        rst_n = 1'b1;
        repeat (HT * VT) @(negedge clk);          // display disabled (R6)
        wr(2'b01, 16'hFFFF, 16'h00FF);            // R7 low lane only
        wr(2'b10, 16'h8000, 16'h80FF);            // R7 high lane, enable on
        repeat (3 * HT * VT) @(negedge clk);
        wr(2'b10, 16'h0000, 16'h00FF);            // R6 disable mid-frame
        repeat (300) @(negedge clk);
        wr(2'b11, 16'h8123, 16'h8123);
        repeat (1700) @(negedge clk);
        wr(2'b00, 16'h0000, 16'h8123);            // R7 no lane: no change
        repeat (HT * VT) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule